// File: doc/BRIEF.md
# Recursive Quadrant Unsigned Multiplier

This block multiplies two unsigned operands with no clock and returns the full double-width product. It is built bottom-up. A 2x2 cell forms four single-bit partial products with AND gates and reduces them with two half adders. Every larger size splits each operand into a low and a high half. It forms the four half-size products with the next smaller multiplier, then merges them through an adder tree that is always two levels deep.

The operand width is a parameter. It must be a power of two and at least 4, and the default is 16. The generator repeats the merge stage once for each doubling of the width, so the 16-bit build has four levels: 2, 4, 8 and 16 bits. The output reflects the inputs as soon as the logic settles, so the block can sit anywhere in a datapath cycle.

Top module: `qd_multiplier`

## Requirements
- R1: `product` equals the unsigned product of `a` and `b` for every operand pair, with the result exactly 2*WIDTH bits wide.
- R2: the 2x2 base cell returns the correct 4-bit product of its two 2-bit inputs, and never exceeds 9 (3 times 3).
- R3: the lowest WIDTH/2 bits of `product` equal the lowest WIDTH/2 bits of the product of the operands' low halves, and pass through with no addition.
- R4: at every merge level, each first-level addition produces no carry out of its width. One adds the upper half of low*low to high*low at N bits. The other adds low*high to high*high shifted up by N/2, at 3N/2 bits.
- R5: the second-level addition of the two first-level sums gives the upper 3N/2 bits of each stage's product with no carry out, so nothing is lost by dropping it.
- R6: if either operand is zero, the product is zero.
- R7: if one operand is 1, the product equals the other operand, zero-extended.
- R8: all-ones operands give the largest product, (2^WIDTH - 1)^2. For WIDTH=16 this is 0xFFFE0001.
- R9: the block is purely combinational. A new operand pair is reflected at `product` within one settling delay, with no clock edge.
- R10: the same structure gives correct products for the 4-bit and 8-bit configurations, over every operand pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | unsigned multiplicand |
| b | input | WIDTH | unsigned multiplier |
| product | output | 2*WIDTH | unsigned product of `a` and `b` |

## Verification
Within one evaluation, the two first-level additions and the second-level merge can all reach their largest sums together at every level. They do so when the operand halves are all ones, or nearly so. The bench provokes this with all-ones operands, with operands whose halves are all ones against zeros, and with exhaustive sweeps of the 4-bit and 8-bit builds. In those sweeps every carry pattern in every level occurs. Each result is compared at the port with the product the bench computes itself, and carry assertions inside each merge stage flag any overflow at the level where it arises.

// File: rtl/qd_pkg.sv
package qd_pkg;

  // Half adder: returns {carry, sum}.
  function automatic logic [1:0] half_add(input logic x, input logic y);
    return {x & y, x ^ y};
  endfunction

  // 2x2 product built from AND terms and two half adders.
  function automatic logic [3:0] cell_product(input logic [1:0] x, input logic [1:0] y);
    logic p0, p1, p2, p3;
    logic [1:0] h1, h2;
    p0 = x[0] & y[0];
    p1 = x[1] & y[0];
    p2 = x[0] & y[1];
    p3 = x[1] & y[1];
    h1 = half_add(p1, p2);
    h2 = half_add(p3, h1[1]);
    return {h2[1], h2[0], h1[0], p0};
  endfunction

  // Shift-and-add reference over the low w bits of the operands.
  function automatic logic [127:0] shift_add_ref(input logic [63:0] x,
                                                 input logic [63:0] y,
                                                 input int unsigned w);
    logic [127:0] acc;
    acc = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < int'(w) && y[i]) acc = acc + ({64'b0, x} << i);
    end
    return acc;
  endfunction

endpackage

// File: rtl/qd_cell2.sv
module qd_cell2
  import qd_pkg::*;
(
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] q
);

  logic [3:0] cell_q;

  always_comb cell_q = cell_product(a, b);
  assign q = cell_q;

  always_comb begin
    if (!$isunknown({a, b, cell_q})) begin
      AST_CELL_MAX: assert (cell_q <= 4'd9)
        else $error("2x2 cell result %0d above 9", cell_q); // R2
      AST_CELL_ZERO: assert (!((a == 2'b00) || (b == 2'b00)) || (cell_q == 4'd0))
        else $error("2x2 cell nonzero with zero operand"); // R6
    end
  end

endmodule

// File: rtl/qd_adder.sv
module qd_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] full;

  always_comb full = {1'b0, x} + {1'b0, y};
  assign sum  = full[W-1:0];
  assign cout = full[W];

endmodule

// File: rtl/qd_combine.sv
module qd_combine #(
  parameter int N = 4
) (
  input  logic [N-1:0]   ll,
  input  logic [N-1:0]   hl,
  input  logic [N-1:0]   lh,
  input  logic [N-1:0]   hh,
  output logic [2*N-1:0] p
);

  localparam int H  = N / 2;
  localparam int WB = 3 * H;

  // First level, branch A: upper half of low*low plus high*low.
  logic [N-1:0]  s1a;
  logic          c1a;
  // First level, branch B: low*high plus high*high shifted up by H.
  logic [WB-1:0] s1b;
  logic          c1b;
  // Second level.
  logic [WB-1:0] s2;
  logic          c2;

  qd_adder #(.W(N)) u_add_a (
    .x   ({{H{1'b0}}, ll[N-1:H]}),
    .y   (hl),
    .sum (s1a),
    .cout(c1a)
  );

  qd_adder #(.W(WB)) u_add_b (
    .x   ({{H{1'b0}}, lh}),
    .y   ({hh, {H{1'b0}}}),
    .sum (s1b),
    .cout(c1b)
  );

  qd_adder #(.W(WB)) u_add_m (
    .x   ({{H{1'b0}}, s1a}),
    .y   (s1b),
    .sum (s2),
    .cout(c2)
  );

  assign p = {s2, ll[H-1:0]};

  always_comb begin
    if (!$isunknown({c1a, c1b, c2})) begin
      AST_STAGE1A_NO_CARRY: assert (c1a == 1'b0)
        else $error("first-level branch A overflow at N=%0d", N); // R4
      AST_STAGE1B_NO_CARRY: assert (c1b == 1'b0)
        else $error("first-level branch B overflow at N=%0d", N); // R4
      AST_MERGE_NO_CARRY: assert (c2 == 1'b0)
        else $error("second-level overflow at N=%0d", N); // R5
    end
  end

endmodule

// File: rtl/qd_multiplier.sv
module qd_multiplier
  import qd_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [2*WIDTH-1:0] product
);

  localparam int LEVELS = $clog2(WIDTH);
  localparam int HALF   = WIDTH / 2;
  localparam logic [127:0] LO_MASK = (128'd1 << HALF) - 128'd1;

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    localparam int S    = 2 << k;
    localparam int CNT  = WIDTH / S;
    localparam int CNTP = CNT * 2;
    logic [2*S-1:0] pr [CNT*CNT];

    if (k == 0) begin : g_base
      for (genvar i = 0; i < CNT; i++) begin : g_i
        for (genvar j = 0; j < CNT; j++) begin : g_j
          qd_cell2 u_cell (
            .a(a[2*i +: 2]),
            .b(b[2*j +: 2]),
            .q(pr[i*CNT+j])
          );
        end
      end
    end else begin : g_comb
      for (genvar i = 0; i < CNT; i++) begin : g_i
        for (genvar j = 0; j < CNT; j++) begin : g_j
          qd_combine #(.N(S)) u_comb (
            .ll(g_lvl[k-1].pr[(2*i)*CNTP   + 2*j]),
            .hl(g_lvl[k-1].pr[(2*i+1)*CNTP + 2*j]),
            .lh(g_lvl[k-1].pr[(2*i)*CNTP   + 2*j+1]),
            .hh(g_lvl[k-1].pr[(2*i+1)*CNTP + 2*j+1]),
            .p (pr[i*CNT+j])
          );
        end
      end
    end
  end

  assign product = g_lvl[LEVELS-1].pr[0];

  logic [127:0] ref_full;
  logic [127:0] ref_low;

  always_comb begin
    ref_full = shift_add_ref(64'(a), 64'(b), WIDTH);
    ref_low  = shift_add_ref(64'(a[HALF-1:0]), 64'(b[HALF-1:0]), HALF);
  end

  always_comb begin
    if (!$isunknown({a, b, product})) begin
      AST_PRODUCT_MATCH: assert (128'(product) == ref_full)
        else $error("product mismatch %0h * %0h", a, b); // R1
      AST_LOW_PASS: assert (((128'(product) ^ ref_low) & LO_MASK) == 128'd0)
        else $error("low product bits differ from low-half product"); // R3
      AST_ZERO_OPERAND: assert (!((a == '0) || (b == '0)) || (product == '0))
        else $error("nonzero product with zero operand"); // R6
    end
  end

endmodule

// File: tb/test_qd_multiplier.sv
module test_qd_multiplier;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [15:0] a16, b16;
  logic [31:0] p16;
  logic [3:0]  a4, b4;
  logic [7:0]  p4;
  logic [7:0]  a8, b8;
  logic [15:0] p8;

  qd_multiplier #(.WIDTH(16)) i_qd_multiplier (.a(a16), .b(b16), .product(p16));
  qd_multiplier #(.WIDTH(4))  i_qd_multiplier_w4 (.a(a4), .b(b4), .product(p4));
  qd_multiplier #(.WIDTH(8))  i_qd_multiplier_w8 (.a(a8), .b(b8), .product(p8));

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic run16(input string req, input logic [15:0] x, input logic [15:0] y);
    a16 = x;
    b16 = y;
    #1;
    check(req, 64'(p16), 64'(x) * 64'(y));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    a16 = '0; b16 = '0; a4 = '0; b4 = '0; a8 = '0; b8 = '0;
    #1;
    check("R6 initial zero", 64'(p16), 64'd0);

    // R6: zero operand
    run16("R6", 16'h0000, 16'hFFFF);
    run16("R6", 16'h1234, 16'h0000);
    // R7: unit operand
    a16 = 16'd1; b16 = 16'hBEEF; #1;
    check("R7", 64'(p16), 64'h0000BEEF);
    a16 = 16'hA5C3; b16 = 16'd1; #1;
    check("R7", 64'(p16), 64'h0000A5C3);
    // R8: all ones
    a16 = 16'hFFFF; b16 = 16'hFFFF; #1;
    check("R8", 64'(p16), 64'hFFFE0001);
    // R9: new operands reflected without a clock edge
    a16 = 16'd2; b16 = 16'd3; #1;
    check("R9", 64'(p16), 64'd6);
    // R2: base cell maximum 3*3
    run16("R2", 16'd3, 16'd3);
    // R4 / R5: half-saturated operands stress both first-level branches and the merge
    run16("R4", 16'hFF00, 16'h00FF);
    run16("R4", 16'h00FF, 16'hFFFF);
    run16("R4", 16'hFFFF, 16'hFF00);
    run16("R5", 16'hFFFE, 16'hFFFF);
    run16("R5", 16'h8000, 16'h8000);
    run16("R5", 16'h7FFF, 16'hFFFF);

    // R1 / R3: pseudo-random 16-bit vectors
    s = 32'h1ACE_B00C;
    for (int n = 0; n < 2000; n++) begin
      s = s ^ (s << 13);
      s = s ^ (s >> 17);
      s = s ^ (s << 5);
      a16 = s[15:0];
      b16 = s[31:16];
      #1;
      check("R1", 64'(p16), 64'(s[15:0]) * 64'(s[31:16]));
      check("R3", 64'(p16[7:0]), 64'((16'(s[7:0]) * 16'(s[23:16])) & 16'h00FF));
    end

    // R10 / R2: exhaustive 4-bit configuration
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        a4 = 4'(x); b4 = 4'(y); #1;
        check("R10 w4", 64'(p4), 64'(x * y));
      end
    end

    // R10: exhaustive 8-bit configuration
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        a8 = 8'(x); b8 = 8'(y); #1;
        check("R10 w8", 64'(p8), 64'(x * y));
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule